// File: doc/BRIEF.md
# Double-Buffered Three-Phase Output Selector

This block decides, pin by pin, whether each of the six outputs of a three-phase PWM stage carries the raw PWM waveform or a fixed level. The pins are U, U-bar, V, V-bar, W and W-bar. Software writes a six-bit setting into a staging register over a minimal register bus and can read it back. A separate active register holds the setting that drives the pins. The active register is refreshed from the staging register on a load event. A trigger-select input makes that event either a compare-match strobe from the timer or a software load strobe.

While the PWM counter is stopped, a bus write also lands directly in the active register, so the pins follow it at once. A pairing mode lets the U, V and W settings govern their complementary pins as well, and the complementary bits are then disregarded. The pin outputs are a purely combinational multiplex of the active bits. The load path has two sources, named by the `trig_src_e` encoding: `TRIG_CMP` and `TRIG_SW`. It chooses between them with a single case decode and needs no sequencing states.

Top module: `opsel_top`

## Requirements
- R1: After reset, `bus_rdata` reads 0xC0 and every pin follows its `pwm_in` bit, because both the staging and the active registers hold 0.
- R2: Pin i (0=U, 1=U-bar, 2=V, 3=V-bar, 4=W, 5=W-bar) outputs `level_in[i]` when active bit i is 1, and `pwm_in[i]` when it is 0. This holds with `pair_mode`=0.
- R3: `bus_rdata[5:0]` returns the staging register and `bus_rdata[7:6]` always reads 2'b11. A write stores `bus_wdata[5:0]` at the next clock edge, and `bus_wdata[7:6]` is discarded.
- R4: While `counter_run`=1, a bus write without a load event leaves the active register, and therefore the pins, unchanged.
- R5: With `trig_sel`=0, a `cmp_match` pulse copies the staging register into the active register at that clock edge, and `sw_load` has no effect.
- R6: With `trig_sel`=1, a `sw_load` pulse copies the staging register into the active register, and `cmp_match` has no effect. `sw_load` acts for the one cycle it is high.
- R7: While `counter_run`=0, a bus write also stores `bus_wdata[5:0]` into the active register at the same edge.
- R8: If a bus write and a load event fall on the same edge, the active register takes the newly written `bus_wdata[5:0]`.
- R9: With `pair_mode`=1, active bits 1, 3 and 5 are ignored. Bit 0 drives both U and U-bar, bit 2 drives both V and V-bar, and bit 4 drives both W and W-bar.
- R10: Without a write-through or a load event, the active register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Staging register write strobe |
| bus_wdata | input | 8 | Write data; bits 7:6 discarded |
| bus_rdata | output | 8 | Staging register readback, bits 7:6 forced high |
| trig_sel | input | 1 | Load trigger: 0 compare match, 1 software strobe |
| cmp_match | input | 1 | Compare-match pulse from the timer |
| sw_load | input | 1 | Software load strobe |
| pair_mode | input | 1 | 1: main-pin bits also govern complementary pins |
| counter_run | input | 1 | 1 when the PWM counter is running |
| pwm_in | input | 6 | Per-pin PWM waveform |
| level_in | input | 6 | Per-pin fixed level |
| pin_out | output | 6 | Pin drive: U, U-bar, V, V-bar, W, W-bar |

## Verification
Directed sequences separate the three ways the active register can change: a gated compare match, a gated software strobe, and a halted write-through. Each sequence also applies the strobe that should be ignored. Complementary level and PWM patterns, such as pwm 0x15 against level 0x2A, make every pin's selection visible. Pairing-mode cases put opposite values in the even and odd bits, so that the controlling bit can be identified. Seeded random cycles then mix all the controls, so that writes collide with loads and triggers switch mid-stream. The results are checked against a bench model of the staging and active registers.

// File: rtl/opsel_pkg.sv
package opsel_pkg;
    localparam int NUM_PHASES = 3;
    localparam int NUM_PINS   = 2 * NUM_PHASES;
    localparam int BUS_W      = 8;
    localparam int PAD_W      = BUS_W - NUM_PINS;

    typedef enum logic {
        TRIG_CMP = 1'b0,
        TRIG_SW  = 1'b1
    } trig_src_e;
endpackage

// File: rtl/opsel_bufreg.sv
module opsel_bufreg #(
    parameter int W     = 6,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [BUS_W-1:0] wdata,
    input  logic             load_evt,
    input  logic             run,
    output logic [W-1:0]     stage_q,
    output logic [W-1:0]     act_q
);
    logic [W-1:0] wval;
    assign wval = wdata[W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (wr) begin
            stage_q <= wval;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (wr && (!run || load_evt)) begin
            act_q <= wval;
        end else if (load_evt) begin
            act_q <= stage_q;
        end
    end

    AST_STAGE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> stage_q == $past(wdata[W-1:0])); // R3
    AST_RUN_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && run && !load_evt) |=> $stable(act_q)); // R4
    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (load_evt && !wr) |=> act_q == $past(stage_q)); // R5
    AST_HALT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !run) |=> act_q == $past(wdata[W-1:0])); // R7
    AST_COLLIDE_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && load_evt) |=> act_q == stage_q); // R8
    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && !load_evt) |=> $stable(act_q)); // R10
endmodule

// File: rtl/opsel_pinmux.sv
module opsel_pinmux #(
    parameter int PHASES = 3,
    parameter int PINS   = 2 * PHASES
) (
    input  logic [PINS-1:0] act,
    input  logic            pair_mode,
    input  logic [PINS-1:0] pwm,
    input  logic [PINS-1:0] lvl,
    output logic [PINS-1:0] pins
);
    for (genvar k = 0; k < PHASES; k++) begin : g_phase
        logic sel_main;
        logic sel_comp;
        assign sel_main = act[2*k];
        assign sel_comp = pair_mode ? act[2*k] : act[2*k+1];
        assign pins[2*k]   = sel_main ? lvl[2*k]   : pwm[2*k];
        assign pins[2*k+1] = sel_comp ? lvl[2*k+1] : pwm[2*k+1];

        always_comb begin
            if (pair_mode && (lvl[2*k+1] != pwm[2*k+1]) && (lvl[2*k] != pwm[2*k]))
                AST_PAIR_TIED: assert ((pins[2*k] == lvl[2*k]) == (pins[2*k+1] == lvl[2*k+1])); // R9
        end
    end
endmodule

// File: rtl/opsel_top.sv
module opsel_top
    import opsel_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic                trig_sel,
    input  logic                cmp_match,
    input  logic                sw_load,
    input  logic                pair_mode,
    input  logic                counter_run,
    input  logic [NUM_PINS-1:0] pwm_in,
    input  logic [NUM_PINS-1:0] level_in,
    output logic [NUM_PINS-1:0] pin_out
);
    logic [NUM_PINS-1:0] stage_q;
    logic [NUM_PINS-1:0] act_q;
    logic                load_evt;
    trig_src_e           src;

    assign src = trig_src_e'(trig_sel);

    always_comb begin
        unique case (src)
            TRIG_CMP: load_evt = cmp_match;
            TRIG_SW:  load_evt = sw_load;
            default:  load_evt = 1'b0;
        endcase
    end

    opsel_bufreg #(.W(NUM_PINS), .BUS_W(BUS_W)) u_bufreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .wdata    (bus_wdata),
        .load_evt (load_evt),
        .run      (counter_run),
        .stage_q  (stage_q),
        .act_q    (act_q)
    );

    assign bus_rdata = {{PAD_W{1'b1}}, stage_q};

    opsel_pinmux #(.PHASES(NUM_PHASES), .PINS(NUM_PINS)) u_pinmux (
        .act       (act_q),
        .pair_mode (pair_mode),
        .pwm       (pwm_in),
        .lvl       (level_in),
        .pins      (pin_out)
    );

    AST_RESERVED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[BUS_W-1:NUM_PINS] == {PAD_W{1'b1}}); // R3
    AST_SW_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_sel && sw_load && !cmp_match && !bus_wr) |=> $stable(act_q)); // R5
    AST_CMP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_sel && cmp_match && !sw_load && !bus_wr) |=> $stable(act_q)); // R6
endmodule

// File: tb/opsel_top_tb_top.sv
module opsel_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       trig_sel = 1'b0;
    logic       cmp_match = 1'b0;
    logic       sw_load = 1'b0;
    logic       pair_mode = 1'b0;
    logic       counter_run = 1'b0;
    logic [5:0] pwm_in = '0;
    logic [5:0] level_in = '0;
    logic [5:0] pin_out;

    int checks = 0;
    int errors = 0;
    logic [5:0] m_stage = '0;
    logic [5:0] m_act = '0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    opsel_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .trig_sel(trig_sel), .cmp_match(cmp_match),
        .sw_load(sw_load), .pair_mode(pair_mode), .counter_run(counter_run),
        .pwm_in(pwm_in), .level_in(level_in), .pin_out(pin_out)
    );

    function automatic logic [5:0] exp_pins(logic [5:0] a, logic pm,
                                            logic [5:0] p, logic [5:0] l);
        logic [5:0] r;
        for (int k = 0; k < 3; k++) begin
            logic cs;
            cs = pm ? a[2*k] : a[2*k+1];
            r[2*k]   = a[2*k] ? l[2*k] : p[2*k];
            r[2*k+1] = cs ? l[2*k+1] : p[2*k+1];
        end
        return r;
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Applies one cycle of stimulus at a negedge, checks outputs, advances model.
    task automatic step(string tag, logic wr, logic [7:0] wd, logic ts,
                        logic cm, logic sl, logic pm, logic run,
                        logic [5:0] p, logic [5:0] l);
        logic ev;
        bus_wr = wr; bus_wdata = wd; trig_sel = ts; cmp_match = cm;
        sw_load = sl; pair_mode = pm; counter_run = run;
        pwm_in = p; level_in = l;
        #1;
        check({tag, " pins"}, {2'b00, pin_out}, {2'b00, exp_pins(m_act, pm, p, l)});
        check({tag, " rdata"}, bus_rdata, {2'b11, m_stage});
        ev = ts ? sl : cm;
        if (wr && (!run || ev)) m_act = wd[5:0];
        else if (ev) m_act = m_stage;
        if (wr) m_stage = wd[5:0];
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5A17;
        void'($urandom(seed));
        repeat (2) @(negedge clk);
        // R1: reset state
        #1;
        check("R1 rdata", bus_rdata, 8'hC0);
        check("R1 pins", {2'b00, pin_out}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        step("R1", 0, 8'h00, 0, 0, 0, 0, 1, 6'h15, 6'h2A);
        // R3: reserved bits discarded and read high
        step("R3", 1, 8'h3F, 0, 0, 0, 0, 1, 6'h15, 6'h2A);
        // R4: running write does not reach pins
        step("R4", 0, 8'h00, 0, 0, 0, 0, 1, 6'h15, 6'h2A);
        step("R3 readback", 1, 8'h05, 0, 0, 0, 0, 1, 6'h15, 6'h2A);
        // R5: sw_load ignored under compare trigger
        step("R5 ignore", 0, 8'h00, 0, 0, 1, 0, 1, 6'h15, 6'h2A);
        step("R5 ignored", 0, 8'h00, 0, 0, 0, 0, 1, 6'h15, 6'h2A);
        step("R5 cmp", 0, 8'h00, 0, 1, 0, 0, 1, 6'h15, 6'h2A);
        // R2: pins now show level where active bit set
        step("R2", 0, 8'h00, 0, 0, 0, 0, 1, 6'h15, 6'h2A);
        step("R2 alt", 1, 8'h2A, 0, 0, 0, 0, 1, 6'h2A, 6'h15);
        // R6: cmp ignored under software trigger
        step("R6 ignore", 0, 8'h00, 1, 1, 0, 0, 1, 6'h15, 6'h2A);
        step("R6 ignored", 0, 8'h00, 1, 0, 0, 0, 1, 6'h15, 6'h2A);
        step("R6 sw", 0, 8'h00, 1, 0, 1, 0, 1, 6'h15, 6'h2A);
        step("R6 result", 0, 8'h00, 1, 0, 0, 0, 1, 6'h15, 6'h2A);
        // R7: halted write-through
        step("R7", 1, 8'h11, 0, 0, 0, 0, 0, 6'h00, 6'h3F);
        step("R7 result", 0, 8'h00, 0, 0, 0, 0, 0, 6'h00, 6'h3F);
        // R8: collision takes new data
        step("R8", 1, 8'h24, 0, 1, 0, 0, 1, 6'h00, 6'h3F);
        step("R8 result", 0, 8'h00, 0, 0, 0, 0, 1, 6'h00, 6'h3F);
        // R9: pairing mode, even bits set odd clear then the reverse
        step("R9 load", 1, 8'h15, 0, 0, 0, 0, 0, 6'h00, 6'h3F);
        step("R9 even", 0, 8'h00, 0, 0, 0, 1, 1, 6'h00, 6'h3F);
        step("R9 load2", 1, 8'h2A, 0, 0, 0, 1, 0, 6'h00, 6'h3F);
        step("R9 odd", 0, 8'h00, 0, 0, 0, 1, 1, 6'h15, 6'h2A);
        // R10: hold across idle cycles
        step("R10", 0, 8'h00, 0, 0, 0, 0, 1, 6'h15, 6'h2A);
        step("R10 hold", 0, 8'h00, 1, 0, 0, 0, 1, 6'h15, 6'h2A);
        // Random mix (R2 R4 R5 R6 R7 R8 R9 R10)
        for (int i = 0; i < 400; i++) begin
            step("R2-mix",
                 ($urandom % 3) == 0, 8'($urandom), 1'($urandom),
                 ($urandom % 4) == 0, ($urandom % 4) == 0, 1'($urandom),
                 ($urandom % 4) != 0, 6'($urandom), 6'($urandom));
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule